// File: doc/BRIEF.md
# BLDC Startup Mode Sequencer

This block decides how a three-phase brushless motor is brought from rest, or from an unknown spin, into closed-loop drive. When the run command rises, it looks at two things. The first is whether an upstream estimator reports a rotation direction. The second is the rotor speed, which the block measures itself from a single digitised Hall level. From these it picks a path. If the motor already turns the commanded way, it goes straight to drive. If it turns the wrong way, it brakes in reverse first. If the direction is unknown, it chooses between aligning at once, short-braking first, or waiting for the rotor to slow.

The startup path runs in a fixed order. The rotor is aligned with two held DC vectors, then stepped open loop at a selectable rate. Drive takes over once the measured Hall frequency exceeds the stepping frequency. The block outputs the current mode, a six-state commutation step index, and a flag that tells the downstream PWM stage which duty source to use. Speed is never computed as a frequency. Every threshold is compared as a Hall period counted in timebase ticks.

Top module: `bldc_start_seq`

## Requirements
- R1: After reset, and one clock after `startCmd` is low in any mode, `mode` is 0 (off). After reset `stepIdx` is 0 and `useStartDuty` is 0. Mode codes: 0 off, 1 short brake, 2 reverse brake, 3 DC align 1, 4 DC align 2, 5 open-loop stepping, 6 drive.
- R2: In off with `startCmd` high, `rotValid` high and `rotDir` equal to `dirCmd`, the next mode is drive.
- R3: In off with `startCmd` high, `rotValid` high and `rotDir` not equal to `dirCmd`, the next mode is reverse brake. Reverse brake holds until the period is slow, then goes to open-loop stepping without DC alignment.
- R4: In off with `startCmd` high and `rotValid` low, the next mode depends on the period. A slow period (at least P40_TICKS ticks) gives DC align 1. A middle period (at least P200_TICKS and below P40_TICKS) gives short brake, which holds until the period is slow and then enters DC align 1. A fast period (below P200_TICKS) keeps the block in off, and it re-evaluates on every clock.
- R5: DC align 1 and DC align 2 each last until T2_TICKS×(`dcSel`+1) ticks have elapsed, then stepping begins. Entering DC align 1 loads step 0 if `hallLvl` is high and step 3 if it is low. Entering DC align 2 and entering stepping each move one step in the commanded direction.
- R6: In open-loop stepping the step moves once per step period. The step period is FC_STEP_TICKS for `fcSel` 0 and 3, FC_STEP_TICKS/2 for 1, and 2×FC_STEP_TICKS for 2.
- R7: Open-loop stepping hands over to drive when the measured period is below 6× the current step period.
- R8: `useStartDuty` is 1 exactly in modes 3, 4 and 5.
- R9: In drive, a change of `dirCmd` gives reverse brake on the next clock. Reverse brake holds until the period is slow, then restarts through DC align 1, DC align 2 and stepping.
- R10: Steps 0..5 are the commutation states in U→V→W order. Forward (`dirCmd` 0) moves +1 mod 6 and reverse (`dirCmd` 1) moves −1 mod 6. In drive, every Hall edge (rising or falling) moves the step by 3.
- R11: The period is the number of ticks between Hall rising edges. While the running count exceeds the last period, the running count is used instead. The count saturates at 2^PER_W−1 and does not wrap, so a stalled rotor reads as slow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startCmd | input | 1 | Run command; low forces off |
| dirCmd | input | 1 | Commanded direction, 0 forward, 1 reverse |
| rotValid | input | 1 | Upstream direction estimate is valid |
| rotDir | input | 1 | Estimated rotation direction |
| hallLvl | input | 1 | Digitised Hall position level |
| tick | input | 1 | Timebase enable, one clock wide |
| dcSel | input | 2 | DC alignment duration code |
| fcSel | input | 2 | Open-loop stepping rate code |
| mode | output | 3 | Current mode code |
| stepIdx | output | 3 | Commutation step 0..5 |
| useStartDuty | output | 1 | 1 selects startup duty, 0 speed-command duty |

## Verification
The bound checker watches the legal mode transitions on every clock:
- the block falls to off whenever the run command is dropped;
- DC align 2 is entered only from DC align 1;
- stepping is entered only from DC align 2 or reverse brake;
- drive is entered only from off or stepping;
- short brake leaves only for DC align 1 or off;
- the step index stays in range.

Period measurement, saturation, DC timing, per-code stepping intervals, step direction and the speed thresholds depend on tick counts and stimulus history. These are shown only by the bench scenarios and its cycle-level reference model.

// File: rtl/bldc_seq_pkg.sv
`timescale 1ns/1ps
package bldc_seq_pkg;

  typedef enum logic [2:0] {
    MD_OFF   = 3'd0,
    MD_SBRK  = 3'd1,
    MD_RBRK  = 3'd2,
    MD_DC1   = 3'd3,
    MD_DC2   = 3'd4,
    MD_FCOM  = 3'd5,
    MD_DRIVE = 3'd6
  } seq_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic tmrClr;
    logic stepLoad;
    logic stepAdv;
    logic stepHalf;
    logic dirRev;
  } seq_strobe_s;

  // datapath -> control status
  typedef struct packed {
    logic slow;
    logic fast;
    logic aboveFc;
    logic t2Done;
    logic stepDue;
    logic hallEdge;
  } seq_status_s;

endpackage

// File: rtl/bldc_seq_datapath.sv
`timescale 1ns/1ps
module bldc_seq_datapath
  import bldc_seq_pkg::*;
#(
  parameter int PER_W         = 10,
  parameter int T2_TICKS      = 24,
  parameter int FC_STEP_TICKS = 16,
  parameter int P40_TICKS     = 100,
  parameter int P200_TICKS    = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        hallLvl,
  input  logic [1:0]  dcSel,
  input  logic [1:0]  fcSel,
  input  seq_strobe_s ctl,
  output seq_status_s stat,
  output logic [2:0]  stepIdx
);

  localparam int CW = PER_W + 4;
  localparam logic [PER_W-1:0] PER_SAT = '1;

  logic             hallPrev;
  logic [PER_W-1:0] perCnt, perLast, tmr, effPer;
  logic [CW-1:0]    t2Ticks, stepTicks, fcElecTicks;
  logic             hallRise, hallEdge;

  assign hallRise = hallLvl & ~hallPrev;
  assign hallEdge = hallLvl ^ hallPrev;

  always_comb begin
    effPer  = (perCnt > perLast) ? perCnt : perLast;
    t2Ticks = CW'(T2_TICKS) * (CW'(dcSel) + CW'(1));
    case (fcSel)
      2'd1:    stepTicks = CW'(FC_STEP_TICKS / 2);
      2'd2:    stepTicks = CW'(FC_STEP_TICKS * 2);
      default: stepTicks = CW'(FC_STEP_TICKS);
    endcase
    fcElecTicks   = stepTicks * CW'(6);
    stat.slow     = CW'(effPer) >= CW'(P40_TICKS);
    stat.fast     = CW'(effPer) <  CW'(P200_TICKS);
    stat.aboveFc  = CW'(effPer) <  fcElecTicks;
    stat.t2Done   = CW'(tmr) >= t2Ticks;
    stat.stepDue  = CW'(tmr) >= stepTicks;
    stat.hallEdge = hallEdge;
  end

  // Hall period measurement in ticks, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hallPrev <= 1'b0;
      perCnt   <= '0;
      perLast  <= PER_SAT;
    end else begin
      hallPrev <= hallLvl;
      if (hallRise) begin
        perLast <= perCnt;
        perCnt  <= '0;
      end else if (tick && perCnt != PER_SAT) begin
        perCnt <= perCnt + 1'b1;
      end
    end
  end

  // shared mode timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     tmr <= '0;
    else if (ctl.tmrClr)           tmr <= '0;
    else if (tick && tmr != PER_SAT) tmr <= tmr + 1'b1;
  end

  // commutation step register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepIdx <= 3'd0;
    end else if (ctl.stepLoad) begin
      stepIdx <= hallLvl ? 3'd0 : 3'd3;
    end else if (ctl.stepAdv) begin
      if (ctl.dirRev) stepIdx <= (stepIdx == 3'd0) ? 3'd5 : stepIdx - 3'd1;
      else            stepIdx <= (stepIdx == 3'd5) ? 3'd0 : stepIdx + 3'd1;
    end else if (ctl.stepHalf) begin
      stepIdx <= (stepIdx >= 3'd3) ? stepIdx - 3'd3 : stepIdx + 3'd3;
    end
  end

endmodule

// File: rtl/bldc_seq_ctrl.sv
`timescale 1ns/1ps
module bldc_seq_ctrl
  import bldc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startCmd,
  input  logic        dirCmd,
  input  logic        rotValid,
  input  logic        rotDir,
  input  seq_status_s stat,
  output seq_mode_e   mode,
  output logic        useStartDuty,
  output seq_strobe_s ctl
);

  seq_mode_e nextMode;
  logic      dirLatch, toDc, nextDir, nextToDc, fcAdv;

  always_comb begin
    nextMode = mode;
    nextDir  = dirLatch;
    nextToDc = toDc;
    fcAdv    = 1'b0;
    ctl      = '0;
    if (!startCmd) begin
      nextMode = MD_OFF;
    end else begin
      case (mode)
        MD_OFF: begin
          nextDir  = dirCmd;
          nextToDc = 1'b0;
          if (rotValid) begin
            nextMode = (rotDir == dirCmd) ? MD_DRIVE : MD_RBRK;
          end else if (stat.slow) begin
            nextMode     = MD_DC1;
            ctl.stepLoad = 1'b1;
          end else if (!stat.fast) begin
            nextMode = MD_SBRK;
          end
        end
        MD_SBRK: begin
          if (stat.slow) begin
            nextMode     = MD_DC1;
            ctl.stepLoad = 1'b1;
          end
        end
        MD_RBRK: begin
          if (stat.slow) begin
            if (toDc) begin
              nextMode     = MD_DC1;
              ctl.stepLoad = 1'b1;
            end else begin
              nextMode = MD_FCOM;
            end
          end
        end
        MD_DC1: begin
          if (stat.t2Done) begin
            nextMode    = MD_DC2;
            ctl.stepAdv = 1'b1;
          end
        end
        MD_DC2: begin
          if (stat.t2Done) begin
            nextMode    = MD_FCOM;
            ctl.stepAdv = 1'b1;
          end
        end
        MD_FCOM: begin
          if (stat.aboveFc) begin
            nextMode = MD_DRIVE;
          end else if (stat.stepDue) begin
            ctl.stepAdv = 1'b1;
            fcAdv       = 1'b1;
          end
        end
        MD_DRIVE: begin
          if (dirCmd != dirLatch) begin
            nextMode = MD_RBRK;
            nextDir  = dirCmd;
            nextToDc = 1'b1;
          end else if (stat.hallEdge) begin
            ctl.stepHalf = 1'b1;
          end
        end
        default: nextMode = MD_OFF;
      endcase
    end
    ctl.tmrClr = (nextMode != mode) | fcAdv;
    ctl.dirRev = dirLatch;
  end

  assign useStartDuty = (mode == MD_DC1) || (mode == MD_DC2) || (mode == MD_FCOM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode     <= MD_OFF;
      dirLatch <= 1'b0;
      toDc     <= 1'b0;
    end else begin
      mode     <= nextMode;
      dirLatch <= nextDir;
      toDc     <= nextToDc;
    end
  end

endmodule

// File: rtl/bldc_start_seq.sv
`timescale 1ns/1ps
module bldc_start_seq
  import bldc_seq_pkg::*;
#(
  parameter int PER_W         = 10,
  parameter int T2_TICKS      = 24,
  parameter int FC_STEP_TICKS = 16,
  parameter int P40_TICKS     = 100,
  parameter int P200_TICKS    = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startCmd,
  input  logic       dirCmd,
  input  logic       rotValid,
  input  logic       rotDir,
  input  logic       hallLvl,
  input  logic       tick,
  input  logic [1:0] dcSel,
  input  logic [1:0] fcSel,
  output logic [2:0] mode,
  output logic [2:0] stepIdx,
  output logic       useStartDuty
);

  seq_strobe_s ctl;
  seq_status_s stat;
  seq_mode_e   modeQ;

  bldc_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .dirCmd(dirCmd),
    .rotValid(rotValid), .rotDir(rotDir), .stat(stat),
    .mode(modeQ), .useStartDuty(useStartDuty), .ctl(ctl)
  );

  bldc_seq_datapath #(
    .PER_W(PER_W), .T2_TICKS(T2_TICKS), .FC_STEP_TICKS(FC_STEP_TICKS),
    .P40_TICKS(P40_TICKS), .P200_TICKS(P200_TICKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .hallLvl(hallLvl),
    .dcSel(dcSel), .fcSel(fcSel), .ctl(ctl), .stat(stat), .stepIdx(stepIdx)
  );

  assign mode = modeQ;

endmodule

// File: rtl/bldc_start_seq_chk.sv
`timescale 1ns/1ps
module bldc_start_seq_chk
  import bldc_seq_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       startCmd,
  input logic [2:0] mode,
  input logic [2:0] stepIdx
);

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !startCmd |=> mode == MD_OFF); // R1

  AST_DC2_FROM_DC1: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MD_DC2 && $past(mode) != MD_DC2) |-> $past(mode) == MD_DC1); // R5

  AST_FCOM_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MD_FCOM && $past(mode) != MD_FCOM) |->
      ($past(mode) == MD_DC2 || $past(mode) == MD_RBRK)); // R3

  AST_DRIVE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MD_DRIVE && $past(mode) != MD_DRIVE) |->
      ($past(mode) == MD_OFF || $past(mode) == MD_FCOM)); // R7

  AST_SBRK_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) == MD_SBRK && mode != MD_SBRK) |->
      (mode == MD_DC1 || mode == MD_OFF)); // R4

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx < 3'd6); // R10

endmodule

bind bldc_start_seq bldc_start_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .startCmd(startCmd), .mode(mode), .stepIdx(stepIdx)
);

// File: tb/bldc_start_seq_tb.sv
`timescale 1ns/1ps
module bldc_start_seq_tb;

  localparam int PW = 10, T2 = 24, FS = 16, P40 = 100, P200 = 20;
  localparam int PSAT = (1 << PW) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic startCmd = 0, dirCmd = 0, rotValid = 0, rotDir = 0;
  logic hallLvl = 1'b0, tick = 1'b0;
  logic [1:0] dcSel = 2'd0, fcSel = 2'd0;
  logic [2:0] mode, stepIdx;
  logic useStartDuty;

  int nChecks = 0, nFail = 0;
  int hallHalfCyc = 0, hallCnt = 0;

  always #2.5 clk = ~clk;

  bldc_start_seq #(.PER_W(PW), .T2_TICKS(T2), .FC_STEP_TICKS(FS),
                   .P40_TICKS(P40), .P200_TICKS(P200)) u_dut (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .dirCmd(dirCmd),
    .rotValid(rotValid), .rotDir(rotDir), .hallLvl(hallLvl), .tick(tick),
    .dcSel(dcSel), .fcSel(fcSel), .mode(mode), .stepIdx(stepIdx),
    .useStartDuty(useStartDuty)
  );

  // timebase: tick on every second clock; Hall generator with period hallHalfCyc ticks
  always @(negedge clk) begin
    tick = ~tick;
    if (hallHalfCyc > 0) begin
      hallCnt++;
      if (hallCnt >= hallHalfCyc) begin hallCnt = 0; hallLvl = ~hallLvl; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mMode, mStep, mPerCnt, mPerLast, mTmr, mHallPrev, mDir, mToDc;
  int eff, stT, nMode, nDir, nToDc;
  bit slow, fast, above, t2d, due, hEdge, hRise, load, adv, half, fcAdv;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mStep = 0; mPerCnt = 0; mPerLast = PSAT; mTmr = 0;
      mHallPrev = 0; mDir = 0; mToDc = 0;
    end else begin
      eff   = (mPerCnt > mPerLast) ? mPerCnt : mPerLast;
      stT   = (fcSel == 1) ? FS / 2 : (fcSel == 2) ? FS * 2 : FS;
      slow  = eff >= P40;  fast = eff < P200;  above = eff < 6 * stT;
      t2d   = mTmr >= T2 * (int'(dcSel) + 1);
      due   = mTmr >= stT;
      hEdge = int'(hallLvl) != mHallPrev;
      hRise = hallLvl && mHallPrev == 0;
      nMode = mMode; nDir = mDir; nToDc = mToDc;
      load = 0; adv = 0; half = 0; fcAdv = 0;
      if (!startCmd) nMode = 0;
      else if (mMode == 0) begin
        nDir = dirCmd; nToDc = 0;
        if (rotValid) nMode = (rotDir == dirCmd) ? 6 : 2;
        else if (slow) begin nMode = 3; load = 1; end
        else if (!fast) nMode = 1;
      end else if (mMode == 1) begin
        if (slow) begin nMode = 3; load = 1; end
      end else if (mMode == 2) begin
        if (slow) begin
          if (mToDc != 0) begin nMode = 3; load = 1; end else nMode = 5;
        end
      end else if (mMode == 3 || mMode == 4) begin
        if (t2d) begin nMode = mMode + 1; adv = 1; end
      end else if (mMode == 5) begin
        if (above) nMode = 6;
        else if (due) begin adv = 1; fcAdv = 1; end
      end else if (mMode == 6) begin
        if (dirCmd != mDir) begin nMode = 2; nDir = dirCmd; nToDc = 1; end
        else if (hEdge) half = 1;
      end
      if (load) mStep = hallLvl ? 0 : 3;
      else if (adv) mStep = (mDir != 0) ? (mStep + 5) % 6 : (mStep + 1) % 6;
      else if (half) mStep = (mStep + 3) % 6;
      if (nMode != mMode || fcAdv) mTmr = 0;
      else if (tick && mTmr < PSAT) mTmr++;
      if (hRise) begin mPerLast = mPerCnt; mPerCnt = 0; end
      else if (tick && mPerCnt < PSAT) mPerCnt++;
      mHallPrev = hallLvl; mMode = nMode; mDir = nDir; mToDc = nToDc;
    end
  end

  function automatic string reqOf(input int m);
    case (m)
      0: return "R1";  1: return "R4";  2: return "R3";
      3, 4: return "R5"; 5: return "R6"; default: return "R10";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      chk(int'(mode) == mMode, reqOf(mMode), "mode vs model", mode, mMode);
      chk(int'(stepIdx) == mStep, "R10", "step vs model", stepIdx, mStep);
      chk(useStartDuty == (mMode >= 3 && mMode <= 5), "R8", "duty select vs model",
          useStartDuty, (mMode >= 3 && mMode <= 5));
    end
  end

  // ---------------- scenario helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitMode(input int m, input int lim, input string req);
    int k;
    k = 0;
    while (int'(mode) != m && k < lim) begin @(negedge clk); k++; end
    chk(int'(mode) == m, req, "mode reached", mode, m);
  endtask

  task automatic stepGap(output int gap, output int prevS, output int newS);
    int k, s0;
    k = 0; s0 = int'(stepIdx);
    while (int'(stepIdx) == s0 && k < 1000) begin @(negedge clk); k++; end
    prevS = int'(stepIdx); gap = 0;
    while (int'(stepIdx) == prevS && gap < 1000) begin @(negedge clk); gap++; end
    newS = int'(stepIdx);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog R1: run did not complete, actual 0 expected 1");
    finishRun();
  end

  initial begin
    int g, a, b, s0, k;
    cyc(6);
    chk(mode == 3'd0, "R1", "reset mode", mode, 0);
    chk(stepIdx == 3'd0, "R1", "reset step", stepIdx, 0);
    chk(useStartDuty == 1'b0, "R1", "reset duty select", useStartDuty, 0);
    rstN = 1'b1;
    cyc(4);

    // unknown direction, stalled rotor: alignment chain
    startCmd = 1; dirCmd = 0; rotValid = 0;
    cyc(1);
    chk(mode == 3'd3, "R4", "slow start enters DC1", mode, 3);
    chk(useStartDuty == 1'b1, "R8", "startup duty in DC1", useStartDuty, 1);
    s0 = hallLvl ? 0 : 3;
    chk(int'(stepIdx) == s0, "R5", "DC1 load step", stepIdx, s0);
    waitMode(4, 200, "R5");
    chk(int'(stepIdx) == (s0 + 1) % 6, "R5", "DC2 step forward", stepIdx, (s0 + 1) % 6);
    waitMode(5, 200, "R5");
    chk(int'(stepIdx) == (s0 + 2) % 6, "R10", "stepping entry step", stepIdx, (s0 + 2) % 6);

    // stepping rate per code
    stepGap(g, a, b);
    chk(g >= 2 * FS && g <= 2 * FS + 3, "R6", "step gap code0", g, 2 * FS + 1);
    chk(b == (a + 1) % 6, "R10", "forward +1", b, (a + 1) % 6);
    fcSel = 2'd1; stepGap(g, a, b); stepGap(g, a, b);
    chk(g >= FS && g <= FS + 3, "R6", "step gap code1", g, FS + 1);
    fcSel = 2'd2; stepGap(g, a, b); stepGap(g, a, b);
    chk(g >= 4 * FS && g <= 4 * FS + 3, "R6", "step gap code2", g, 4 * FS + 1);
    fcSel = 2'd3; stepGap(g, a, b); stepGap(g, a, b);
    chk(g >= 2 * FS && g <= 2 * FS + 3, "R6", "step gap code3", g, 2 * FS + 1);
    fcSel = 2'd0;

    // Hall speeds up past stepping frequency: handover
    hallHalfCyc = 40;
    waitMode(6, 600, "R7");
    chk(useStartDuty == 1'b0, "R8", "speed duty in drive", useStartDuty, 0);
    stepGap(g, a, b);
    chk(b == (a + 3) % 6, "R10", "drive Hall edge +3", b, (a + 3) % 6);

    // direction change in drive
    dirCmd = 1;
    cyc(1);
    chk(mode == 3'd2, "R9", "reverse brake on dir change", mode, 2);
    cyc(50);
    chk(mode == 3'd2, "R9", "brake holds while fast", mode, 2);
    hallHalfCyc = 0;
    waitMode(3, 600, "R9");
    s0 = int'(stepIdx);
    waitMode(4, 200, "R9");
    chk(int'(stepIdx) == (s0 + 5) % 6, "R10", "DC2 step reverse", stepIdx, (s0 + 5) % 6);
    waitMode(5, 200, "R9");

    // stop
    startCmd = 0;
    cyc(1);
    chk(mode == 3'd0, "R1", "start removed gives off", mode, 0);
    chk(useStartDuty == 1'b0, "R1", "off duty select", useStartDuty, 0);

    // direction agrees
    rotValid = 1; rotDir = 1; dirCmd = 1; startCmd = 1;
    cyc(1);
    chk(mode == 3'd6, "R2", "agreeing direction goes to drive", mode, 6);
    startCmd = 0; cyc(2);

    // direction disagrees, rotor moving
    hallHalfCyc = 40; cyc(300);
    rotDir = 0; startCmd = 1;
    cyc(1);
    chk(mode == 3'd2, "R3", "opposing direction brakes", mode, 2);
    cyc(30);
    chk(mode == 3'd2, "R3", "brake holds while fast", mode, 2);
    hallHalfCyc = 0;
    k = 0;
    while (mode == 3'd2 && k < 600) begin @(negedge clk); k++; end
    chk(mode == 3'd5, "R3", "brake exits to stepping", mode, 5);
    startCmd = 0; rotValid = 0; cyc(2);

    // unknown direction, middle speed
    hallHalfCyc = 50; cyc(400);
    startCmd = 1;
    cyc(1);
    chk(mode == 3'd1, "R4", "middle speed short brake", mode, 1);
    cyc(40);
    chk(mode == 3'd1, "R4", "short brake holds", mode, 1);
    hallHalfCyc = 0;
    waitMode(3, 600, "R4");
    startCmd = 0; cyc(2);

    // slow but moving rotor counts as slow
    hallHalfCyc = 120; cyc(800);
    startCmd = 1;
    cyc(1);
    chk(mode == 3'd3, "R11", "moving slow Hall enters DC1", mode, 3);
    startCmd = 0; cyc(2);

    // fast rotor: stays off and retries
    hallHalfCyc = 10; cyc(200);
    startCmd = 1;
    cyc(60);
    chk(mode == 3'd0, "R4", "fast rotor keeps off", mode, 0);
    startCmd = 0;

    // saturation: stall just past counter range
    hallHalfCyc = 0;
    cyc(2 * (PSAT + 8));
    dcSel = 2'd3; startCmd = 1;
    cyc(1);
    chk(mode == 3'd3, "R11", "saturated period reads slow", mode, 3);
    k = 0;
    while (mode == 3'd3 && k < 1000) begin @(negedge clk); k++; end
    chk(k >= 2 * T2 * 4 - 1 && k <= 2 * T2 * 4 + 3, "R5", "DC1 length code3", k, 2 * T2 * 4);
    startCmd = 0; cyc(3);

    finishRun();
  end

endmodule